// File: doc/BRIEF.md
# Length-Detecting Three-Wire Serial Receiver

This block takes serial words framed by an enable line and decides what each word means from the number of bits it carries. While the enable line is high, a bit is taken on every falling edge of the serial clock. The first four bits drive a port register, which is loaded part-way through the frame. The frequency field and the control fields are then loaded by a rule that depends on whether the finished word held 18, 19 or 27 bits. For the two short formats, the word length also sets one of the reference-ratio select bits.

The serial lines are asynchronous to the system clock. They pass through a synchronizer of parameterised depth, and all edge detection is done in the system clock domain. In a 27-bit word the frequency field is loaded in the middle of the frame, on a counted serial clock edge. The control fields are loaded when the enable line falls.

Top module: `tw_length_rx`

## Requirements
- R1: After reset: port register 0, frequency register 0, charge-pump-high 1, test mode 3'b001, ratio-A 0, ratio-B 1, tuning-off 1.
- R2: The first four bits of a frame are loaded into the port register on the 5th rising serial clock edge, before the enable line falls. The first bit goes to port bit 3 and the fourth bit to port bit 0. A frame of fewer than 5 bits leaves the port register unchanged.
- R3: Data is sampled on the falling serial clock edge while the enable line is high. Serial clock activity while the enable line is low has no effect.
- R4: When the enable line falls after an 18-bit word, the frequency register takes {0, bits 5..18} and ratio-A is set to 1. All other control fields are left as they were.
- R5: When the enable line falls after a 19-bit word, the frequency register takes bits 5..19 (bit 5 is the MSB) and ratio-A is cleared to 0. All other control fields are left as they were.
- R6: In a 27-bit word, the frequency register takes bits 5..19 on the 20th rising serial clock edge, while the enable line is still high. When the enable line falls, the control fields are loaded as follows: bit 20 is charge-pump-high, bits 21..23 are test mode [2:0], bit 24 is ratio-A, bit 25 is ratio-B and bit 26 is tuning-off. Bit 27 is ignored.
- R7: A word of fewer than 18 bits leaves the frequency register and all control fields unchanged.
- R8: A word of 20 to 26 bits, or of more than 27 bits, leaves all control fields, including ratio-A, unchanged. In such a word only the port load on the 5th edge and the frequency load on the 20th edge take place.
- R9: Every rising edge of the enable line restarts the bit count, so an aborted earlier frame does not shift the fields of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_en | input | 1 | Frame enable line (asynchronous) |
| fr_sck | input | 1 | Serial clock (asynchronous) |
| fr_sd | input | 1 | Serial data (asynchronous) |
| port_o | output | PORT_W | Port register |
| freq_o | output | FREQ_W | Frequency divider register |
| chg_pump_hi_o | output | 1 | Charge pump high-current select |
| test_mode_o | output | 3 | Test mode bits |
| ratio_a_o | output | 1 | Reference ratio select A |
| ratio_b_o | output | 1 | Reference ratio select B |
| tune_off_o | output | 1 | Tuning output disable |

## Verification
The hardest case to reach is the mid-frame frequency load of a 27-bit word. It is only visible while the enable line is still high, between the 20th serial clock edge and the end of the frame. The bench therefore sends the first 20 bits, holds the enable line high and checks the frequency register before it sends the remaining bits. On every bit, the bench drives the inverted data value before the rising serial edge and the true value only while the clock is high, so sampling on the wrong edge yields wrong fields. Aborted frames, serial clocks toggled while the enable line is low, and the lengths 3, 12, 22 and 30 bring about the cases where a field must be left as it was.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

   // Control fields, listed from the earliest received bit to the latest
   typedef struct packed {
      logic       cp;
      logic [2:0] tst;
      logic       rsa;
      logic       rsb;
      logic       tune_off;
   } ctrl_t;

   // Serial control field width, including one trailing spare bit
   localparam int CTRL_BITS = $bits(ctrl_t) + 1;

   localparam ctrl_t CTRL_RESET = '{cp: 1'b1, tst: 3'b001, rsa: 1'b0,
                                    rsb: 1'b1, tune_off: 1'b1};

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tw_frame.sv
module tw_frame #(
   parameter int PORT_W = 4,
   parameter int FREQ_W = 15,
   parameter int SH_W   = 27,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sck,
   input  logic              sd,
   output logic [SH_W-1:0]   sh_q,
   output logic [CNT_W-1:0]  word_len,
   output logic              port_ld,
   output logic              freq_ld,
   output logic              word_end
);

   localparam int PORT_EDGE = PORT_W + 1;
   localparam int FREQ_EDGE = PORT_W + FREQ_W + 1;

   logic             en_d, sck_d;
   logic [CNT_W-1:0] rise_cnt, fall_cnt;
   logic             en_rise, sck_rise, sck_fall;

   assign en_rise  = en & ~en_d;
   assign word_end = ~en & en_d;
   assign sck_rise = en & en_d & sck & ~sck_d;
   assign sck_fall = en & en_d & ~sck & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d     <= 1'b0;
         sck_d    <= 1'b0;
         rise_cnt <= '0;
         fall_cnt <= '0;
         sh_q     <= '0;
      end else begin
         en_d  <= en;
         sck_d <= sck;
         if (en_rise) begin
            rise_cnt <= '0;
            fall_cnt <= '0;
         end else begin
            if (sck_rise && rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
            if (sck_fall) begin
               sh_q <= {sh_q[SH_W-2:0], sd};
               if (fall_cnt != '1) fall_cnt <= fall_cnt + 1'b1;
            end
         end
      end
   end

   // The count of edges already seen, so the Nth edge matches N-1
   assign port_ld  = sck_rise && (rise_cnt == CNT_W'(PORT_EDGE - 1));
   assign freq_ld  = sck_rise && (rise_cnt == CNT_W'(FREQ_EDGE - 1));
   assign word_len = fall_cnt;

endmodule

// File: rtl/tw_commit.sv
module tw_commit
   import tw_rx_pkg::*;
#(
   parameter int PORT_W = 4,
   parameter int FREQ_W = 15,
   parameter int SH_W   = 27,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SH_W-1:0]   sh,
   input  logic [CNT_W-1:0]  word_len,
   input  logic              port_ld,
   input  logic              freq_ld,
   input  logic              word_end,
   output logic [PORT_W-1:0] port_q,
   output logic [FREQ_W-1:0] freq_q,
   output ctrl_t             ctrl_q
);

   localparam int SHORT_LEN = PORT_W + FREQ_W - 1;
   localparam int MID_LEN   = PORT_W + FREQ_W;
   localparam int LONG_LEN  = SH_W;

   logic is_short, is_mid, is_long;
   logic unused_sh;

   assign is_short  = word_end && (word_len == CNT_W'(SHORT_LEN));
   assign is_mid    = word_end && (word_len == CNT_W'(MID_LEN));
   assign is_long   = word_end && (word_len == CNT_W'(LONG_LEN));
   assign unused_sh = ^{sh[SH_W-1:FREQ_W], sh[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '0;
         freq_q <= '0;
         ctrl_q <= CTRL_RESET;
      end else begin
         if (port_ld) port_q <= sh[PORT_W-1:0];
         if (freq_ld) freq_q <= sh[FREQ_W-1:0];
         if (is_short) begin
            freq_q     <= {1'b0, sh[FREQ_W-2:0]};
            ctrl_q.rsa <= 1'b1;
         end else if (is_mid) begin
            freq_q     <= sh[FREQ_W-1:0];
            ctrl_q.rsa <= 1'b0;
         end else if (is_long) begin
            ctrl_q <= ctrl_t'(sh[CTRL_BITS-1:1]);
         end
      end
   end

endmodule

// File: rtl/tw_length_rx.sv
module tw_length_rx
   import tw_rx_pkg::*;
#(
   parameter int PORT_W      = 4,
   parameter int FREQ_W      = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fr_en,
   input  logic              fr_sck,
   input  logic              fr_sd,
   output logic [PORT_W-1:0] port_o,
   output logic [FREQ_W-1:0] freq_o,
   output logic              chg_pump_hi_o,
   output logic [2:0]        test_mode_o,
   output logic              ratio_a_o,
   output logic              ratio_b_o,
   output logic              tune_off_o
);

   localparam int SH_W  = PORT_W + FREQ_W + CTRL_BITS;
   localparam int CNT_W = $clog2(SH_W + 2);

   generate
      if (PORT_W < 1 || FREQ_W < 2) begin : g_bad_width
         $error("tw_length_rx: PORT_W must be >= 1 and FREQ_W >= 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("tw_length_rx: SYNC_STAGES must be >= 0");
      end
   endgenerate

   logic [2:0]       sync_q;
   logic [SH_W-1:0]  sh;
   logic [CNT_W-1:0] word_len;
   logic             port_ld, freq_ld, word_end;
   ctrl_t            ctrl_q;

   tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({fr_en, fr_sck, fr_sd}),
      .q     (sync_q)
   );

   tw_frame #(.PORT_W(PORT_W), .FREQ_W(FREQ_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sync_q[2]),
      .sck      (sync_q[1]),
      .sd       (sync_q[0]),
      .sh_q     (sh),
      .word_len (word_len),
      .port_ld  (port_ld),
      .freq_ld  (freq_ld),
      .word_end (word_end)
   );

   tw_commit #(.PORT_W(PORT_W), .FREQ_W(FREQ_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .sh       (sh),
      .word_len (word_len),
      .port_ld  (port_ld),
      .freq_ld  (freq_ld),
      .word_end (word_end),
      .port_q   (port_o),
      .freq_q   (freq_o),
      .ctrl_q   (ctrl_q)
   );

   assign chg_pump_hi_o = ctrl_q.cp;
   assign test_mode_o   = ctrl_q.tst;
   assign ratio_a_o     = ctrl_q.rsa;
   assign ratio_b_o     = ctrl_q.rsb;
   assign tune_off_o    = ctrl_q.tune_off;

endmodule

// File: rtl/tw_length_rx_chk.sv
module tw_length_rx_chk #(
   parameter int PORT_W = 4,
   parameter int FREQ_W = 15,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PORT_W-1:0] port_o,
   input logic [FREQ_W-1:0] freq_o,
   input logic              chg_pump_hi_o,
   input logic [2:0]        test_mode_o,
   input logic              ratio_a_o,
   input logic              ratio_b_o,
   input logic              tune_off_o,
   input logic              port_ld,
   input logic              freq_ld,
   input logic              word_end,
   input logic [CNT_W-1:0]  word_len
);

   localparam int SHORT_LEN = PORT_W + FREQ_W - 1;
   localparam int MID_LEN   = PORT_W + FREQ_W;
   localparam int LONG_LEN  = PORT_W + FREQ_W + 8;

   logic [6:0] ctl;
   logic       end_short, end_mid, end_long;
   assign ctl       = {chg_pump_hi_o, test_mode_o, ratio_a_o, ratio_b_o, tune_off_o};
   assign end_short = word_end && (word_len == CNT_W'(SHORT_LEN));
   assign end_mid   = word_end && (word_len == CNT_W'(MID_LEN));
   assign end_long  = word_end && (word_len == CNT_W'(LONG_LEN));

   p_port_only_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !port_ld |=> $stable(port_o));

   p_short_sets_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
      end_short |=> (ratio_a_o && !freq_o[FREQ_W-1]));

   p_mid_clears_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      end_mid |=> !ratio_a_o);

   p_ctrl_only_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(end_long || end_short || end_mid) |=> $stable(ctl));

   p_freq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(freq_ld || end_short || end_mid) |=> $stable(freq_o));

endmodule

bind tw_length_rx tw_length_rx_chk #(.PORT_W(PORT_W), .FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .port_o        (port_o),
   .freq_o        (freq_o),
   .chg_pump_hi_o (chg_pump_hi_o),
   .test_mode_o   (test_mode_o),
   .ratio_a_o     (ratio_a_o),
   .ratio_b_o     (ratio_b_o),
   .tune_off_o    (tune_off_o),
   .port_ld       (port_ld),
   .freq_ld       (freq_ld),
   .word_end      (word_end),
   .word_len      (word_len)
);

// File: tb/tb_tw_length_rx.sv
module tb_tw_length_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fr_en = 1'b0, fr_sck = 1'b0, fr_sd = 1'b0;
   logic [3:0]  port_o;
   logic [14:0] freq_o;
   logic        chg_pump_hi_o, ratio_a_o, ratio_b_o, tune_off_o;
   logic [2:0]  test_mode_o;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   tw_length_rx dut (
      .clk (clk), .rst_n (rst_n), .fr_en (fr_en), .fr_sck (fr_sck), .fr_sd (fr_sd),
      .port_o (port_o), .freq_o (freq_o), .chg_pump_hi_o (chg_pump_hi_o),
      .test_mode_o (test_mode_o), .ratio_a_o (ratio_a_o), .ratio_b_o (ratio_b_o),
      .tune_off_o (tune_off_o)
   );

   function automatic logic [6:0] ctl();
      return {chg_pump_hi_o, test_mode_o, ratio_a_o, ratio_b_o, tune_off_o};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Wrong value before the rising edge, true value only while the clock is high
   task automatic put_bits(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         fr_sd = ~w[i];
         tick(4);
         fr_sck = 1'b1;
         tick(2);
         fr_sd = w[i];
         tick(2);
         fr_sck = 1'b0;
         tick(4);
      end
   endtask

   task automatic start_frame();
      fr_en = 1'b1;
      tick(4);
   endtask

   task automatic end_frame();
      fr_en = 1'b0;
      tick(8);
   endtask

   task automatic send(input logic [31:0] w, input int n);
      start_frame();
      put_bits(w, n);
      end_frame();
   endtask

   task automatic t_reset();
      chk("R1 port", port_o, 0);
      chk("R1 freq", freq_o, 0);
      chk("R1 ctrl", ctl(), 7'b1_001_0_1_1);
   endtask

   task automatic t_word18();
      send({4'hA, 14'h1ABC}, 18);
      chk("R2 port 18", port_o, 4'hA);
      chk("R4 freq 18", freq_o, 15'h1ABC);
      chk("R4 ctrl 18", ctl(), 7'b1_001_1_1_1);
   endtask

   task automatic t_word19();
      send({4'h5, 15'h6D2F}, 19);
      chk("R5 port 19", port_o, 4'h5);
      chk("R5 freq 19", freq_o, 15'h6D2F);
      chk("R5 ctrl 19", ctl(), 7'b1_001_0_1_1);
   endtask

   task automatic t_word27();
      logic [26:0] w;
      w = {4'h3, 15'h1234, 8'b0_110_1_0_0_1};
      start_frame();
      put_bits(32'(w[26:7]), 20);
      chk("R6 freq mid-frame", freq_o, 15'h1234);
      chk("R6 ctrl held mid-frame", ctl(), 7'b1_001_0_1_1);
      put_bits(32'(w[6:0]), 7);
      end_frame();
      chk("R6 port 27", port_o, 4'h3);
      chk("R6 ctrl 27", ctl(), 7'b0_110_1_0_0);
   endtask

   task automatic t_keep_after_short();
      send({4'hC, 15'h0055}, 19);
      chk("R5 freq keeps ctrl", freq_o, 15'h0055);
      chk("R5 other ctrl kept", ctl(), 7'b0_110_0_0_0);
      send({4'hC, 14'h0077}, 18);
      chk("R4 other ctrl kept", ctl(), 7'b0_110_1_0_0);
   endtask

   task automatic t_short12();
      send({4'h9, 8'hFF}, 12);
      chk("R2 port 12", port_o, 4'h9);
      chk("R7 freq 12", freq_o, 15'h0077);
      chk("R7 ctrl 12", ctl(), 7'b0_110_1_0_0);
   endtask

   task automatic t_tiny();
      send(32'h0000_0002, 3);
      chk("R2 port tiny", port_o, 4'h9);
      chk("R7 freq tiny", freq_o, 15'h0077);
   endtask

   task automatic t_len22();
      send({4'h6, 15'h0F0F, 3'b101}, 22);
      chk("R8 port 22", port_o, 4'h6);
      chk("R8 freq 22", freq_o, 15'h0F0F);
      chk("R8 ctrl 22", ctl(), 7'b0_110_1_0_0);
   endtask

   task automatic t_len30();
      send({4'h1, 15'h7001, 8'h00, 3'b000}, 30);
      chk("R8 port 30", port_o, 4'h1);
      chk("R8 freq 30", freq_o, 15'h7001);
      chk("R8 ctrl 30", ctl(), 7'b0_110_1_0_0);
   endtask

   task automatic t_idle_clock();
      for (int i = 0; i < 24; i++) begin
         fr_sd = i[0];
         tick(2);
         fr_sck = 1'b1;
         tick(2);
         fr_sck = 1'b0;
      end
      tick(8);
      chk("R3 port idle", port_o, 4'h1);
      chk("R3 freq idle", freq_o, 15'h7001);
      chk("R3 ctrl idle", ctl(), 7'b0_110_1_0_0);
   endtask

   task automatic t_restart();
      send(32'h0000_007B, 7);
      chk("R9 port aborted", port_o, 4'hF);
      send({4'h2, 15'h4321}, 19);
      chk("R9 port restart", port_o, 4'h2);
      chk("R9 freq restart", freq_o, 15'h4321);
      chk("R9 ratio restart", ratio_a_o, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(4);
      t_reset();
      t_word18();
      t_word19();
      t_word27();
      t_keep_after_short();
      t_short12();
      t_tiny();
      t_len22();
      t_len30();
      t_idle_clock();
      t_restart();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule